// File: doc/BRIEF.md
# DDC EDID Read Engine

This block reads display identification data from a monitor over the DDC two-wire link. Software sets up a transfer by writing one control word. That word carries a byte count, a transaction type and an enable bit. The engine then runs the bus on its own. It writes a device address with word offset zero, issues a repeated start, and clocks in the requested bytes. Each byte goes into a sixteen-word buffer that software reads through the register port.

Transfers longer than 64 bytes are split into chunks. When a chunk fills the buffer and more bytes are still to come, the engine sets a buffer-full status bit and holds SCL low. It waits there until software sets the continue bit, and then refills the buffer from word 0. When the last byte arrives, the engine NACKs it, sends a STOP and sets the done bit. All status bits are cleared by writing one to them. The interrupt line is high whenever an enabled status bit is set. A pulse on the hot-plug input only sets its own status bit.

The SCL and SDA outputs are logic levels: 1 releases the line and 0 pulls it low. An open-drain pad outside the block turns these into wired-AND lines, and the line level comes back on `sda_i`.

Top module: `ddc_edid_reader`

## Requirements
- R1: After reset, the control, interrupt-enable and status registers read 0, `irq` is 0, and `scl_o` and `sda_o` are 1. Both lines stay at 1 whenever the engine is idle.
- R2: The control register sits at offset 0x00. Its fields are: enable at bit 0, continue at bit 1, type at [3:2] and byte count at [28:20]. A transfer starts only on a write made while the engine is idle and enable is 0, when that write sets enable, sets type 3 (EDID read) and gives a non-zero count. Any other type, or a count of 0, stores the fields with no bus activity and no status change. While a transfer runs, control writes affect only the continue bit.
- R3: On the bus, a transfer is START, address byte 0xA0, offset byte 0x00, repeated START, address byte 0xA1, then the data bytes. SDA changes only while SCL is low, except inside START and STOP.
- R4: Received bytes are stored little-endian. Byte n of the current chunk sits in the word at offset 0x40 + 4*(n/4), bits [8*(n%4)+7 : 8*(n%4)]. Each new chunk starts again at word 0.
- R5: When the 64th byte of a chunk is stored and bytes remain, status bit 3 (full) is set. SCL is then held low, and no further byte is transferred until continue is written.
- R6: The continue bit is taken only while the engine is paused. It reads back as 0 once the engine resumes. Writing it at any other time has no effect.
- R7: After the last byte, which the engine NACKs, a STOP is sent and status bit 2 (done) is set. A final chunk of 64 bytes or fewer sets done without setting full.
- R8: While enable is still 1 after a transfer, writing enable as 1 again starts nothing. Enable must be written 0 before a new transfer can start.
- R9: The status register sits at offset 0x08. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: The interrupt-enable register sits at offset 0x04. Its writable bits are 4 (error), 3 (full), 2 (done) and 0 (hot-plug), and bit 1 reads 0. `irq` is 1 exactly when a status bit and its enable bit are both 1.
- R11: If the sink NACKs the address byte or the offset byte, status bit 4 (error) is set. A STOP is sent and the engine returns to idle with both lines released, without setting done.
- R12: A one-cycle pulse on `hpd_evt` sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| hpd_evt | input | 1 | Hot-plug event pulse |
| scl_o | output | 1 | SCL level (1 = released) |
| sda_o | output | 1 | SDA level (1 = released) |
| sda_i | input | 1 | SDA line level |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs reads of 1, 4 and 63 bytes, which each fit in one partial chunk. It runs a read of exactly 64 bytes, which must end with done and no full event. It also runs reads of 65, 128 and 130 bytes; these separate the rule for a full chunk followed by more bytes from the rule for a final chunk, and they test that each refill starts at word 0. A modelled sink returns a known byte pattern. That pattern shows byte order and chunk boundaries. The sink also reports the address sequence, the byte count and the NACK on the last byte. A NACK on the address byte and a NACK on the offset byte test the two abort points. Writes of a non-EDID type, a repeated enable and a stray continue each check that the bus stays quiet.

// File: rtl/ddc_edid_reader.sv
module ddc_edid_reader #(
  parameter int         QDIV   = 2,
  parameter int         CNT_W  = 9,
  parameter int         ADDR_W = 8,
  parameter logic [6:0] DEV_ID = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              hpd_evt,
  output logic              scl_o,
  output logic              sda_o,
  input  logic              sda_i,
  output logic              irq
);
  localparam int BUF_WORDS = 16;
  localparam int PTR_W     = $clog2(BUF_WORDS * 4);
  localparam int QC_W      = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam int CNT_LSB   = 20;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h08);
  localparam logic [4:0]        IEN_MASK = 5'b11101;

  typedef enum logic [2:0] {S_IDLE, S_START, S_TX, S_TXACK, S_RX, S_RXACK, S_PAUSE, S_STOP} st_t;

  st_t              st;
  logic [QC_W-1:0]  qcnt;
  logic [1:0]       q, seg;
  logic [2:0]       bitn;
  logic [7:0]       sh;
  logic [CNT_W-1:0] rem, ctrl_cnt;
  logic [PTR_W-1:0] wptr;
  logic             nak, err_stop, ctrl_en, cont_req;
  logic [1:0]       ctrl_type;
  logic [4:0]       ien, stat, stat_set, stat_clr;
  logic [31:0]      bufw [BUF_WORDS];
  logic             scl_q, sda_q, scl_nx, sda_nx;
  logic [31:0]      ctrl_word;

  wire unused_wdata = ^{reg_wdata[31:CNT_LSB+CNT_W], reg_wdata[CNT_LSB-1:5]};

  wire ctrl_wr = reg_wr && reg_addr == A_CTRL;
  wire go      = ctrl_wr && st == S_IDLE && !ctrl_en && reg_wdata[0] &&
                 reg_wdata[3:2] == 2'd3 && reg_wdata[CNT_LSB +: CNT_W] != '0;
  wire resume  = st == S_PAUSE && cont_req;
  wire running = st != S_IDLE && st != S_PAUSE;
  wire tick    = running && qcnt == QC_W'(QDIV - 1);
  wire endq    = tick && q == 2'd3;
  wire store   = endq && st == S_RX && bitn == 3'd7;

  assign stat_set[0] = hpd_evt;
  assign stat_set[1] = 1'b0;
  assign stat_set[2] = endq && st == S_STOP && !err_stop;
  assign stat_set[3] = endq && st == S_RXACK && rem != '0 && wptr == '0;
  assign stat_set[4] = endq && st == S_TXACK && nak;
  assign stat_clr    = (reg_wr && reg_addr == A_STAT) ? reg_wdata[4:0] : 5'd0;
  assign irq         = |(stat & ien);
  assign scl_o       = scl_q;
  assign sda_o       = sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_en <= 1'b0; ctrl_type <= '0; ctrl_cnt <= '0;
      cont_req <= 1'b0; ien <= '0; stat <= '0;
    end else begin
      if (ctrl_wr && st == S_IDLE) begin
        ctrl_en   <= reg_wdata[0];
        ctrl_type <= reg_wdata[3:2];
        ctrl_cnt  <= reg_wdata[CNT_LSB +: CNT_W];
      end
      cont_req <= st == S_PAUSE && !resume && (cont_req || (ctrl_wr && reg_wdata[1]));
      if (reg_wr && reg_addr == A_IEN) ien <= reg_wdata[4:0] & IEN_MASK;
      stat <= (stat & ~stat_clr) | stat_set;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; qcnt <= '0; q <= '0; seg <= '0; bitn <= '0; sh <= '0;
      rem <= '0; wptr <= '0; nak <= 1'b0; err_stop <= 1'b0;
    end else if (go) begin
      st <= S_START; qcnt <= '0; q <= '0; seg <= '0; wptr <= '0;
      rem <= reg_wdata[CNT_LSB +: CNT_W]; err_stop <= 1'b0;
    end else if (resume) begin
      st <= S_RX; qcnt <= '0; q <= '0; bitn <= '0;
    end else if (running) begin
      qcnt <= tick ? '0 : qcnt + 1'b1;
      if (tick) begin
        q <= q + 2'd1;
        case (st)
          S_START: if (q == 2'd3) begin
            st <= S_TX; sh <= {DEV_ID, seg == 2'd2}; bitn <= '0;
          end
          S_TX: if (q == 2'd3) begin
            if (bitn == 3'd7) st <= S_TXACK;
            else begin sh <= sh << 1; bitn <= bitn + 3'd1; end
          end
          S_TXACK: begin
            if (q == 2'd2) nak <= sda_i;
            if (q == 2'd3) begin
              if (nak) begin st <= S_STOP; err_stop <= 1'b1; end
              else if (seg == 2'd0) begin seg <= 2'd1; st <= S_TX; sh <= 8'h00; bitn <= '0; end
              else if (seg == 2'd1) begin seg <= 2'd2; st <= S_START; end
              else begin st <= S_RX; bitn <= '0; end
            end
          end
          S_RX: begin
            if (q == 2'd2) sh <= {sh[6:0], sda_i};
            if (q == 2'd3) begin
              if (bitn == 3'd7) begin
                st <= S_RXACK; rem <= rem - 1'b1; wptr <= wptr + 1'b1;
              end else bitn <= bitn + 3'd1;
            end
          end
          S_RXACK: if (q == 2'd3) begin
            bitn <= '0;
            if (rem == '0) st <= S_STOP;
            else if (wptr == '0) st <= S_PAUSE;
            else st <= S_RX;
          end
          S_STOP: if (q == 2'd3) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < BUF_WORDS; i++) bufw[i] <= '0;
    end else if (store) begin
      bufw[wptr[PTR_W-1:2]][{wptr[1:0], 3'b000} +: 8] <= sh;
    end

  always_comb begin
    scl_nx = 1'b1;
    sda_nx = 1'b1;
    case (st)
      S_START: case (q)
        2'd0: scl_nx = seg == 2'd0;
        2'd2: sda_nx = 1'b0;
        2'd3: begin scl_nx = 1'b0; sda_nx = 1'b0; end
        default: ;
      endcase
      S_TX: begin scl_nx = q == 2'd1 || q == 2'd2; sda_nx = sh[7]; end
      S_TXACK, S_RX: scl_nx = q == 2'd1 || q == 2'd2;
      S_RXACK: begin scl_nx = q == 2'd1 || q == 2'd2; sda_nx = rem == '0; end
      S_PAUSE: scl_nx = 1'b0;
      S_STOP: case (q)
        2'd0: begin scl_nx = 1'b0; sda_nx = 1'b0; end
        2'd1: sda_nx = 1'b0;
        default: ;
      endcase
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin scl_q <= 1'b1; sda_q <= 1'b1; end
    else begin scl_q <= scl_nx; sda_q <= sda_nx; end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[0] = ctrl_en;
    ctrl_word[1] = cont_req;
    ctrl_word[3:2] = ctrl_type;
    ctrl_word[CNT_LSB +: CNT_W] = ctrl_cnt;
    if (reg_addr[ADDR_W-1:6] == (ADDR_W-6)'(1)) reg_rdata = bufw[reg_addr[5:2]];
    else case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_word;
      A_IEN:   reg_rdata = {27'd0, ien};
      A_STAT:  reg_rdata = {27'd0, stat};
      default: reg_rdata = '0;
    endcase
  end

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) == S_IDLE) |-> (scl_o && sda_o));
  // R3
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && $past(st) != S_START && $past(st) != S_STOP) |-> $stable(sda_o));
  // R5
  pause_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAUSE && $past(st) == S_PAUSE) |-> !scl_o);
  // R5
  full_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[3]) |-> (st == S_PAUSE && wptr == '0));
  // R6
  cont_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cont_req |-> st == S_PAUSE);
  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[2]) |-> (st == S_IDLE && rem == '0));
  // R11
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[4]) |-> st == S_STOP);
endmodule

// File: tb/tb_ddc_edid_reader.sv
module tb_ddc_edid_reader;
  logic clk = 0, rst_n = 0, reg_wr = 0, hpd_evt = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic scl_o, sda_o, irq;
  logic sink_sda = 1;
  wire sda_line = sda_o & sink_sda;

  ddc_edid_reader dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hpd_evt(hpd_evt), .scl_o(scl_o),
    .sda_o(sda_o), .sda_i(sda_line), .irq(irq));

  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0;

  // sink model
  int s_state = 0, s_bit = 0, s_ptr = 0, s_bytes = 0, scl_falls = 0;
  logic [7:0] s_sh = 0;
  bit s_ok = 0, s_nak = 0, last_nak = 0, seen_a0 = 0, seen_off = 0, seen_a1 = 0;
  bit nack_addr = 0, nack_off = 0;

  function automatic logic [7:0] dat(int p);
    return 8'((p * 37 + 11) & 255);
  endfunction
  function automatic logic dbit(int p, int b);
    logic [7:0] v = dat(p);
    return v[b];
  endfunction

  always @(negedge sda_line) if (scl_o === 1'b1) begin s_state = 1; s_bit = 0; sink_sda = 1; end
  always @(posedge sda_line) if (scl_o === 1'b1) s_state = 0;
  always @(posedge scl_o) begin
    if (s_state == 1 || s_state == 2) begin
      if (s_bit < 8) s_sh = {s_sh[6:0], sda_line};
      s_bit++;
    end else if (s_state == 3) begin
      if (s_bit == 8) s_nak = sda_line;
      s_bit++;
    end
  end
  always @(negedge scl_o) begin
    scl_falls++;
    if (s_state == 1 || s_state == 2) begin
      if (s_bit == 8) begin
        s_ok = (s_state == 1) ? (s_sh[7:1] == 7'h50 && !nack_addr) : !nack_off;
        sink_sda = !s_ok;
      end else if (s_bit == 9) begin
        sink_sda = 1; s_bit = 0;
        if (!s_ok) s_state = 0;
        else if (s_state == 2) begin s_ptr = int'(s_sh); seen_off = (s_sh == 8'h00); s_state = 0; end
        else if (s_sh[0]) begin seen_a1 = 1; s_state = 3; s_nak = 0; sink_sda = dbit(s_ptr, 7); end
        else begin seen_a0 = 1; s_state = 2; end
      end
    end else if (s_state == 3) begin
      if (s_bit < 8) sink_sda = dbit(s_ptr, 7 - s_bit);
      else if (s_bit == 8) sink_sda = 1;
      else begin
        s_bytes++; s_ptr++; s_bit = 0;
        if (s_nak) begin last_nak = 1; s_state = 0; sink_sda = 1; end
        else begin last_nak = 0; sink_sda = dbit(s_ptr, 7); end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_irq(int lim, output bit got);
    got = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (irq) begin got = 1; break; end
    end
  endtask

  function automatic logic [31:0] ctrl_val(int cnt, int typ, bit en);
    return (32'(cnt) << 20) | (32'(typ) << 2) | 32'(en);
  endfunction

  localparam int NV = 7;
  localparam int VEC_CNT [NV]  = '{1, 4, 63, 64, 65, 128, 130};
  localparam int VEC_FULL [NV] = '{0, 0, 0, 0, 1, 1, 2};

  bit stall_done = 0;

  task automatic run_read(int cnt, int exp_full, bit clear_en);
    logic [31:0] s, w, c;
    int fulls = 0, b0, nlast, b;
    bit got, done = 0, ok;
    b0 = s_bytes; seen_a0 = 0; seen_off = 0; seen_a1 = 0; last_nak = 0;
    wr(8'h00, ctrl_val(cnt, 3, 1));
    while (!done) begin
      wait_irq(30000, got);
      if (!got) begin chk(0, "R7", "irq timeout", 0, 1); break; end
      repeat (5) @(negedge clk);
      rd(8'h08, s);
      if (s[3]) begin
        ok = 1;
        for (int k = 0; k < 16; k++) begin
          rd(8'h40 + 8'(4 * k), w);
          for (int j = 0; j < 4; j++) if (w[8*j +: 8] !== dat(64 * fulls + 4 * k + j)) ok = 0;
        end
        chk(ok, "R4", "full chunk words", 32'(fulls), 32'(fulls));
        chk(s[2] == 0, "R5", "no done with full", s, 32'h8);
        if (!stall_done) begin
          stall_done = 1; b = s_bytes;
          repeat (300) @(negedge clk);
          chk(s_bytes == b && scl_o == 0, "R5", "stall while full", 32'(s_bytes), 32'(b));
        end
        fulls++;
        wr(8'h08, 32'h8);
        wr(8'h00, ctrl_val(cnt, 3, 1) | 32'h2);
        repeat (3) @(negedge clk);
        rd(8'h00, c);
        chk(c[1] == 0, "R6", "continue self-clears", c, ctrl_val(cnt, 3, 1));
      end else if (s[2]) begin
        done = 1;
        nlast = cnt - 64 * fulls;
        ok = 1;
        for (int n = 0; n < nlast; n++) begin
          rd(8'h40 + 8'(4 * (n / 4)), w);
          if (w[8 * (n % 4) +: 8] !== dat(64 * fulls + n)) ok = 0;
        end
        chk(ok, "R4", "final chunk bytes", 32'(nlast), 32'(nlast));
        chk(fulls == exp_full, "R7", "full events before done", 32'(fulls), 32'(exp_full));
        chk(s_bytes - b0 == cnt && last_nak, "R7", "byte count and last NACK", 32'(s_bytes - b0), 32'(cnt));
        chk(seen_a0 && seen_off && seen_a1, "R3", "address sequence", {29'd0, seen_a0, seen_off, seen_a1}, 32'h7);
        wr(8'h08, 32'h4);
        if (clear_en) wr(8'h00, 0);
      end else begin
        chk(0, "R11", "unexpected status", s, 32'h4);
        break;
      end
    end
  endtask

  task automatic nack_case(bit on_addr);
    logic [31:0] s;
    bit got;
    int b = s_bytes;
    nack_addr = on_addr; nack_off = !on_addr;
    wr(8'h00, ctrl_val(4, 3, 1));
    wait_irq(5000, got);
    rd(8'h08, s);
    chk(got && s == 32'h10, "R11", on_addr ? "error on address NACK" : "error on offset NACK", s, 32'h10);
    repeat (100) @(negedge clk);
    rd(8'h08, s);
    chk(scl_o && sda_o && s_bytes == b && s == 32'h10, "R11", "idle after abort, no done",
        {s[30:0], scl_o & sda_o}, 32'h21);
    wr(8'h08, 32'h10); wr(8'h00, 0);
    nack_addr = 0; nack_off = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int f;
    bit got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, d); chk(d == 0, "R1", "ctrl after reset", d, 0);
    rd(8'h04, d); chk(d == 0, "R1", "ien after reset", d, 0);
    rd(8'h08, d); chk(d == 0, "R1", "status after reset", d, 0);
    chk(scl_o && sda_o && !irq, "R1", "lines and irq after reset", {scl_o, sda_o, irq}, 3'b110);

    // R10 enable bits
    wr(8'h04, 32'h1F); rd(8'h04, d);
    chk(d == 32'h1D, "R10", "enable mask", d, 32'h1D);

    for (int v = 0; v < NV; v++) run_read(VEC_CNT[v], VEC_FULL[v], 1);

    // R2 non-EDID type and zero count
    f = scl_falls;
    wr(8'h00, ctrl_val(4, 2, 1));
    repeat (300) @(negedge clk);
    rd(8'h08, d);
    chk(scl_falls == f && d == 0, "R2", "HDCP type ignored", 32'(scl_falls - f), 0);
    rd(8'h00, d); chk(d == ctrl_val(4, 2, 1), "R2", "ctrl fields stored", d, ctrl_val(4, 2, 1));
    wr(8'h00, 0);
    wr(8'h00, ctrl_val(0, 3, 1));
    repeat (300) @(negedge clk);
    chk(scl_falls == f, "R2", "zero count ignored", 32'(scl_falls - f), 0);
    wr(8'h00, 0);

    // R6 stray continue
    wr(8'h00, 32'h2);
    repeat (50) @(negedge clk);
    rd(8'h00, d);
    chk(d == 0 && scl_falls == f, "R6", "continue while idle", d, 0);

    // R8 re-enable without clear
    run_read(2, 0, 0);
    f = scl_falls;
    wr(8'h00, ctrl_val(2, 3, 1));
    repeat (300) @(negedge clk);
    rd(8'h08, d);
    chk(scl_falls == f && d == 0, "R8", "no restart while enabled", 32'(scl_falls - f), 0);
    wr(8'h00, 0);
    run_read(3, 0, 1);

    // R11
    nack_case(1);
    nack_case(0);

    // R12, R9, R10
    @(negedge clk); hpd_evt = 1; @(negedge clk); hpd_evt = 0;
    rd(8'h08, d);
    chk(d == 1 && irq, "R12", "hot-plug sets bit 0", d, 1);
    wr(8'h08, 0); rd(8'h08, d);
    chk(d == 1, "R9", "write 0 keeps bit", d, 1);
    wr(8'h04, 0); #1;
    chk(!irq, "R10", "masked irq", {31'd0, irq}, 0);
    wr(8'h04, 32'h1D); #1;
    chk(irq, "R10", "unmasked irq", {31'd0, irq}, 1);
    wr(8'h08, 1); rd(8'h08, d);
    chk(d == 0 && !irq, "R9", "write 1 clears bit", d, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule